// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the low address bits of a four-beat burst for a synchronous burst memory. When a new burst opens, it takes the two lowest bits of the external address as its starting point. Each later clock edge on which the active-low advance input is sampled low moves it one beat forward. It can walk the group either in plain ascending order modulo four or in an order formed by XOR with the beat index.

The surrounding memory controller keeps the upper address bits and drives the array with the bits this block produces. A flag marks the fourth beat of the group. After that beat the sequence returns to its starting value instead of stopping. An edge on which advance is high holds the current address, and the controller uses such edges as wait states.

Top module: `burst_seq_gen`

## Requirements
- R1: While reset (`rstN` low) is applied and after it is released with no other activity, `lowAddr` is 0 and `lastBeat` is 0.
- R2: An edge with `startBurst` high captures `addrLow` as the starting value. From that edge on, `lowAddr` equals that value and `lastBeat` is 0.
- R3: With `interleaveSel` = 0 captured at the load, the beats are start, start+1, start+2, start+3, all modulo 4. For example, start 2 gives 2,3,0,1.
- R4: With `interleaveSel` = 1 captured at the load, beat n outputs start XOR n. For example, start 1 gives 1,0,3,2 and start 3 gives 3,2,1,0.
- R5: On an edge with `startBurst` low and `advN` high, `lowAddr` and `lastBeat` keep their values.
- R6: On an edge with `startBurst` high, `advN` has no effect. The first beat is the loaded value even when `advN` is low.
- R7: An advance taken on the fourth beat returns `lowAddr` to the loaded starting value, with `lastBeat` 0.
- R8: A change of `interleaveSel` between loads does not alter the order of the burst in progress. It applies from the next load.
- R9: `lastBeat` is 1 exactly while the fourth beat (beat index 3) is presented.
- R10: A load in the middle of a burst restarts the sequence at the new starting value at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startBurst | input | 1 | High: load a new starting value on this edge |
| advN | input | 1 | Low: move one beat forward on this edge |
| interleaveSel | input | 1 | Order select, captured at load: 0 ascending, 1 XOR |
| addrLow | input | CNT_W | Low bits of the external address |
| lowAddr | output | CNT_W | Current low address bits |
| lastBeat | output | 1 | High on the final beat of the group |

## Verification
Both outputs are decoded combinationally from registers that update on the same edge as the load or advance that changes them. Every result is therefore due one edge after its stimulus. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the next rising edge, so each check reads exactly the beat that edge produced. Hold checks sample after an edge that carried no advance, and mode-change checks sample after the first advance that follows the change.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Strobes handed from the control decode to the datapath
  typedef struct packed {
    logic load;  // capture new starting value, clear beat index
    logic step;  // advance beat index by one
  } burstStrb_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic       startBurst,
  input  logic       advN,
  output burstStrb_t strb
);
  // A load takes priority: advance is not honoured on the load edge
  always_comb begin
    strb.load = startBurst;
    strb.step = !advN && !startBurst;
  end
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  burstStrb_t       strb,
  input  logic [CNT_W-1:0] addrLow,
  input  logic             modeIn,
  output logic [CNT_W-1:0] lowAddr,
  output logic             lastBeat
);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_BEAT = '1;
  localparam logic [CNT_W-1:0] PRE_LAST  = LAST_BEAT - ONE;

  logic [CNT_W-1:0] startVal;
  logic [CNT_W-1:0] beatCnt;
  logic             modeReg;
  logic [CNT_W-1:0] linearAddr;
  logic [CNT_W-1:0] xorAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startVal <= '0;
      beatCnt  <= '0;
      modeReg  <= 1'b0;
    end else if (strb.load) begin
      startVal <= addrLow;
      beatCnt  <= '0;
      modeReg  <= modeIn;
    end else if (strb.step) begin
      beatCnt  <= beatCnt + ONE;
    end
  end

  always_comb begin
    linearAddr = startVal + beatCnt;
    xorAddr    = startVal ^ beatCnt;
    lowAddr    = modeReg ? xorAddr : linearAddr;
    lastBeat   = (beatCnt == LAST_BEAT);
  end

  // R2
  load_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (beatCnt == '0) && (lowAddr == $past(addrLow)));

  // R5
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> $stable(lowAddr) && $stable(lastBeat));

  // R7
  wrap_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && lastBeat) |=> (lowAddr == startVal) && !lastBeat);

  // R9
  last_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && beatCnt == PRE_LAST) |=> lastBeat);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(modeReg));
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startBurst,
  input  logic             advN,
  input  logic             interleaveSel,
  input  logic [CNT_W-1:0] addrLow,
  output logic [CNT_W-1:0] lowAddr,
  output logic             lastBeat
);
  burstStrb_t strb;

  burst_seq_ctrl ctrl_i (
    .startBurst (startBurst),
    .advN       (advN),
    .strb       (strb)
  );

  burst_seq_dp #(.CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addrLow  (addrLow),
    .modeIn   (interleaveSel),
    .lowAddr  (lowAddr),
    .lastBeat (lastBeat)
  );
endmodule

// File: tb/burst_seq_gen_tb_top.sv
module burst_seq_gen_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startBurst = 1'b0;
  logic       advN = 1'b1;
  logic       interleaveSel = 1'b0;
  logic [1:0] addrLow = 2'd0;
  logic [1:0] lowAddr;
  logic       lastBeat;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  burst_seq_gen #(.CNT_W(2)) dut_i (
    .clk(clk), .rstN(rstN), .startBurst(startBurst), .advN(advN),
    .interleaveSel(interleaveSel), .addrLow(addrLow),
    .lowAddr(lowAddr), .lastBeat(lastBeat)
  );

  // {mode, start, beat0, beat1, beat2, beat3}
  localparam logic [10:0] VEC [8] = '{
    11'b0_00_00_01_10_11, 11'b0_01_01_10_11_00,
    11'b0_10_10_11_00_01, 11'b0_11_11_00_01_10,
    11'b1_00_00_01_10_11, 11'b1_01_01_00_11_10,
    11'b1_10_10_11_00_01, 11'b1_11_11_10_01_00
  };

  task automatic chk(input string req, input logic [1:0] expA, input logic expL);
    checks++;
    if (lowAddr !== expA || lastBeat !== expL) begin
      fails++;
      $display("FAIL %s: lowAddr=%0d lastBeat=%0b expected lowAddr=%0d lastBeat=%0b",
               req, lowAddr, lastBeat, expA, expL);
    end
  endtask

  task automatic drive(input logic sb, input logic adv, input logic md, input logic [1:0] a);
    startBurst = sb; advN = adv; interleaveSel = md; addrLow = a;
    @(posedge clk); #1;
  endtask

  initial begin
    #1;
    chk("R1 in reset", 2'd0, 1'b0);
    @(posedge clk); #1;
    rstN = 1'b1;
    drive(1'b0, 1'b1, 1'b0, 2'd3);
    chk("R1 after reset", 2'd0, 1'b0);

    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      string ord;
      v = VEC[i];
      ord = v[10] ? "R4" : "R3";
      drive(1'b1, 1'b0, v[10], v[9:8]);          // load with advance low
      chk("R2/R6 load beat0", v[7:6], 1'b0);
      drive(1'b0, 1'b1, ~v[10], 2'd0);           // wait state
      chk("R5 hold", v[7:6], 1'b0);
      drive(1'b0, 1'b0, ~v[10], 2'd0);
      chk({ord, " beat1"}, v[5:4], 1'b0);
      drive(1'b0, 1'b0, v[10], 2'd0);
      chk({ord, " beat2"}, v[3:2], 1'b0);
      drive(1'b0, 1'b0, v[10], 2'd0);
      chk({ord, "/R9 beat3"}, v[1:0], 1'b1);
      drive(1'b0, 1'b1, v[10], 2'd0);
      chk("R5 hold last", v[1:0], 1'b1);
      drive(1'b0, 1'b0, v[10], 2'd0);
      chk("R7 wrap", v[7:6], 1'b0);
    end

    // R8: mode flip during a linear burst keeps the linear order
    drive(1'b1, 1'b1, 1'b0, 2'd1);
    drive(1'b0, 1'b0, 1'b0, 2'd0);
    chk("R8 pre-flip", 2'd2, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 2'd0);
    chk("R8 after flip", 2'd3, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 2'd1);
    drive(1'b0, 1'b0, 1'b1, 2'd0);
    chk("R8 next load XOR", 2'd0, 1'b0);

    // R10: reload mid-burst
    drive(1'b0, 1'b0, 1'b1, 2'd0);
    drive(1'b1, 1'b0, 1'b0, 2'd2);
    chk("R10 reload", 2'd2, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 2'd0);
    chk("R10 after reload", 2'd3, 1'b0);

    // R1: reset mid-burst
    drive(1'b0, 1'b0, 1'b0, 2'd0);
    rstN = 1'b0; #1;
    chk("R1 async reset", 2'd0, 1'b0);
    rstN = 1'b1;
    drive(1'b0, 1'b1, 1'b0, 2'd0);
    chk("R1 post reset", 2'd0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule